// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four shared level-sensitive PCI interrupt lines (lines A to D) and drives the sixteen inputs of a pair of legacy interrupt controllers. Each line has its own byte-wide route register. Software reaches the four route registers through a byte register port. A route value names the controller input that the line drives, or it leaves the line disconnected. A controller input may collect several lines, and it is then high while any one of them is high.

Internally the block holds a map with one bit for each pair of controller input and line. The bit for input `c` and line `p` sits at position `c*4 + p`. A route write clears the map and rebuilds it from the present line levels under the new routes. Outside route writes, each line refreshes only the bit at its own route. The outputs are registered.

Two combinational helpers sit beside the router. A route query reports whether a chosen line is connected and, if so, to which input. A slot swizzle turns a device's interrupt pin and its device/function number into the line index that device uses.

Top module: `irq_line_router`

## Requirements
- R1: While reset is asserted and after it is released, all four route registers read 0x80 and every controller output is low.
- R2: A write to byte address 0x60, 0x61, 0x62 or 0x63 stores the write byte in the route register of line A, B, C or D in that order. A read of one of those addresses returns the stored byte unchanged. A read of any other address returns 0x00.
- R3: A write to any address outside 0x60 to 0x63 changes no route register and no output.
- R4: A route value below 16 connects the line to the controller input of that number.
- R5: A route value of 16 or more disconnects the line, whatever its low four bits hold (0x10, 0x80, 0x8F). A disconnected line drives no output.
- R6: A controller output is high exactly when at least one line connected to it is high. This is the wired OR of every line routed to that input.
- R7: Outputs reflect the line levels and routes sampled at a rising clock edge, and they are visible right after that edge. A route write therefore takes effect one clock after it is presented, using the levels present at that same edge.
- R8: The internal map holds at most one set bit per line. The bit for line p and input c sits at position c*4+p.
- R9: The route query for a line returns enable=1 and the target equal to the low four bits of the route when the route is below 16. Otherwise it returns enable=0 and target 0.
- R10: The swizzle output equals (pin + (devfn >> 3) - 1) mod 4, where pin 0 to 3 stands for INTA to INTD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pirq_lvl | input | 4 | Interrupt line levels; bit 0 is line A |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Byte write enable |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte (combinational) |
| pic_irq | output | 16 | Controller input levels |
| qry_line | input | 2 | Line index for the route query |
| qry_en | output | 1 | The queried line is connected |
| qry_target | output | 4 | Controller input of the queried line |
| sw_devfn | input | 8 | Device/function number for the swizzle |
| sw_pin | input | 2 | Interrupt pin for the swizzle (0 = INTA) |
| sw_line | output | 2 | Line index produced by the swizzle |

## Verification
The assertions assume that the line levels and the register port are synchronous to the clock and settle well before each rising edge. The bench therefore changes every input only on the falling edge. The assertions also assume that reg_addr and reg_we hold a defined value at every edge once reset is released. The bench keeps reg_we low between writes and drives the address to a known value at all times. Line levels change together with a route write, or alone, so that the rebuild path and the per-line refresh path are both exercised.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_LINES  = 4;
  localparam int NUM_INPUTS = 16;
  localparam int LINE_W     = $clog2(NUM_LINES);
  localparam int INPUT_W    = $clog2(NUM_INPUTS);
  localparam int MAP_W      = NUM_LINES * NUM_INPUTS;

  typedef logic [NUM_LINES-1:0][7:0] route_bank_t;

  // A route byte connects its line only when it names an existing input.
  function automatic logic route_ok(input logic [7:0] r);
    return int'(r) < NUM_INPUTS;
  endfunction

  // Bit position of the (input, line) pair in the state map.
  function automatic int map_pos(input logic [7:0] r, input int line);
    return int'(r[INPUT_W-1:0]) * NUM_LINES + line;
  endfunction

  // Slot swizzle: a device's pin rotated by its slot number.
  function automatic logic [LINE_W-1:0] slot_line(input logic [7:0] devfn,
                                                  input logic [1:0] pin);
    int sum;
    sum = int'(pin) + int'(devfn[7:3]) + NUM_LINES - 1;
    return LINE_W'(sum % NUM_LINES);
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR   = 8'h60,
  parameter logic [7:0] RESET_ROUTE = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic        we,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output route_bank_t routes_q,
  output route_bank_t routes_d,
  output logic        wr_hit
);
  localparam int LAST = int'(BASE_ADDR) + NUM_LINES - 1;

  logic             in_window;
  logic [LINE_W-1:0] sel;

  assign in_window = (int'(addr) >= int'(BASE_ADDR)) && (int'(addr) <= LAST);
  assign sel       = LINE_W'(addr - BASE_ADDR);
  assign wr_hit    = we && in_window;

  always_comb begin
    routes_d = routes_q;
    if (wr_hit) routes_d[sel] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) routes_q <= {NUM_LINES{RESET_ROUTE}};
    else        routes_q <= routes_d;
  end

  assign rdata = in_window ? routes_q[sel] : 8'h00;
endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] levels,
  input  route_bank_t          routes_d,
  input  logic                 rebuild,
  output logic [MAP_W-1:0]     map_q
);
  logic [MAP_W-1:0] map_d;

  always_comb begin
    map_d = map_q;
    // A route change invalidates every pair, so start from an empty map.
    if (rebuild) map_d = '0;
    for (int p = 0; p < NUM_LINES; p++) begin
      if (route_ok(routes_d[p])) map_d[map_pos(routes_d[p], p)] = levels[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end
endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin
  import irq_router_pkg::*;
(
  input  logic [MAP_W-1:0]      map_q,
  output logic [NUM_INPUTS-1:0] pic_irq
);
  for (genvar c = 0; c < NUM_INPUTS; c++) begin : g_in
    assign pic_irq[c] = |map_q[c*NUM_LINES +: NUM_LINES];
  end
endmodule

// File: rtl/irq_route_query.sv
module irq_route_query
  import irq_router_pkg::*;
(
  input  route_bank_t        routes_q,
  input  logic [LINE_W-1:0]  qry_line,
  output logic               qry_en,
  output logic [INPUT_W-1:0] qry_target,
  input  logic [7:0]         sw_devfn,
  input  logic [1:0]         sw_pin,
  output logic [LINE_W-1:0]  sw_line
);
  logic [7:0] picked;

  assign picked     = routes_q[qry_line];
  assign qry_en     = route_ok(picked);
  assign qry_target = qry_en ? picked[INPUT_W-1:0] : '0;
  assign sw_line    = slot_line(sw_devfn, sw_pin);
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  pirq_lvl,
  input  logic [7:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [15:0] pic_irq,
  input  logic [1:0]  qry_line,
  output logic        qry_en,
  output logic [3:0]  qry_target,
  input  logic [7:0]  sw_devfn,
  input  logic [1:0]  sw_pin,
  output logic [1:0]  sw_line
);
  route_bank_t      routes_q;
  route_bank_t      routes_d;
  logic             wr_hit;
  logic [MAP_W-1:0] map_q;

  irq_route_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .routes_q(routes_q), .routes_d(routes_d), .wr_hit(wr_hit)
  );

  irq_route_map u_map (
    .clk(clk), .rst_n(rst_n), .levels(pirq_lvl), .routes_d(routes_d),
    .rebuild(wr_hit), .map_q(map_q)
  );

  irq_route_fanin u_fanin (.map_q(map_q), .pic_irq(pic_irq));

  irq_route_query u_query (
    .routes_q(routes_q), .qry_line(qry_line), .qry_en(qry_en),
    .qry_target(qry_target), .sw_devfn(sw_devfn), .sw_pin(sw_pin),
    .sw_line(sw_line)
  );
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
  import irq_router_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       pirq_lvl,
  input logic             reg_we,
  input logic [15:0]      pic_irq,
  input logic [1:0]       qry_line,
  input logic             qry_en,
  input logic [3:0]       qry_target,
  input route_bank_t      routes_q,
  input logic [MAP_W-1:0] map_q,
  input logic             wr_hit
);
  logic [NUM_LINES-1:0][NUM_INPUTS-1:0] per_line;

  always_comb begin
    for (int p = 0; p < NUM_LINES; p++)
      for (int c = 0; c < NUM_INPUTS; c++)
        per_line[p][c] = map_q[c*NUM_LINES + p];
  end

  // R3
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !wr_hit) |=> $stable(routes_q));

  // R6
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_irq != 16'h0) |-> ($past(pirq_lvl) != 4'h0));

  // R9
  query_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_en |-> (qry_target == routes_q[qry_line][3:0]));

  // R9
  query_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_en |-> (qry_target == 4'h0));

  for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
    // R8
    one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(per_line[p]) <= 1);

    // R5
    detached_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !route_ok(routes_q[p]) |-> (per_line[p] == '0));
  end
endmodule

bind irq_line_router irq_line_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .reg_we(reg_we),
  .pic_irq(pic_irq), .qry_line(qry_line), .qry_en(qry_en),
  .qry_target(qry_target), .routes_q(routes_q), .map_q(map_q),
  .wr_hit(wr_hit)
);

// File: tb/irq_line_router_bench.sv
module irq_line_router_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pirq_lvl;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] pic_irq;
  logic [1:0]  qry_line;
  logic        qry_en;
  logic [3:0]  qry_target;
  logic [7:0]  sw_devfn;
  logic [1:0]  sw_pin;
  logic [1:0]  sw_line;

  int checks = 0;
  int errors = 0;

  irq_line_router u_irq_line_router (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0]  addr;
    logic [7:0]  data;
    logic [3:0]  lvl;
    logic [15:0] exp_pic;
  } vec_t;

  // Route write, levels at the same edge, outputs expected afterwards.
  localparam vec_t VECS [8] = '{
    '{8'h60, 8'h03, 4'b0001, 16'h0008},  // R4 A->3
    '{8'h61, 8'h03, 4'b0011, 16'h0008},  // R6 A,B share 3
    '{8'h62, 8'h0F, 4'b0111, 16'h8008},  // R4 C->15
    '{8'h63, 8'h00, 4'b1111, 16'h8009},  // R4 D->0
    '{8'h61, 8'h10, 4'b1111, 16'h8009},  // R5 B off at 0x10
    '{8'h60, 8'h8F, 4'b0001, 16'h0000},  // R5 A off at 0x8F
    '{8'h70, 8'h05, 4'b1111, 16'h8001},  // R3 outside window
    '{8'h62, 8'h00, 4'b0100, 16'h0001}   // R6 C moves to 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d, input logic [3:0] lvl);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; pirq_lvl = lvl;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; pirq_lvl = 4'h0; reg_addr = 8'h00; reg_we = 1'b0;
    reg_wdata = 8'h00; qry_line = 2'd0; sw_devfn = 8'h00; sw_pin = 2'd0;
    repeat (3) @(negedge clk);
    pirq_lvl = 4'hF;
    #1;
    chk("R1 outputs in reset", 32'(pic_irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pirq_lvl = 4'h0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      read_byte(8'h60 + 8'(i), rd);
      chk("R1 route reset value", 32'(rd), 32'h80);
    end
    chk("R1 outputs after reset", 32'(pic_irq), 32'h0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      write_byte(VECS[i].addr, VECS[i].data, VECS[i].lvl);
      chk($sformatf("R6 R7 vector %0d outputs", i), 32'(pic_irq), 32'(VECS[i].exp_pic));
      if (VECS[i].addr inside {[8'h60:8'h63]}) begin
        read_byte(VECS[i].addr, rd);
        chk($sformatf("R2 vector %0d readback", i), 32'(rd), 32'(VECS[i].data));
      end
    end

    // R3: ignored write left the routes unchanged, reads outside window give 0
    read_byte(8'h70, rd);
    chk("R3 R2 read outside window", 32'(rd), 32'h0);
    read_byte(8'h60, rd); chk("R3 line A route", 32'(rd), 32'h8F);
    read_byte(8'h61, rd); chk("R3 line B route", 32'(rd), 32'h10);
    read_byte(8'h62, rd); chk("R3 line C route", 32'(rd), 32'h00);
    read_byte(8'h63, rd); chk("R3 line D route", 32'(rd), 32'h00);

    // R7: level change without a write, timing around the edge
    write_byte(8'h60, 8'h05, 4'b0000);
    chk("R7 all low", 32'(pic_irq), 32'h0);
    pirq_lvl = 4'b0001;
    #1;
    chk("R7 no change before edge", 32'(pic_irq), 32'h0);
    @(negedge clk);
    chk("R7 change after one edge", 32'(pic_irq), 32'h0020);
    pirq_lvl = 4'b1000;
    @(negedge clk);
    chk("R6 R7 line A drops, D rises", 32'(pic_irq), 32'h0001);

    // R9: route query
    qry_line = 2'd0; #1;
    chk("R9 line A enabled", 32'(qry_en), 32'h1);
    chk("R9 line A target", 32'(qry_target), 32'h5);
    qry_line = 2'd1; #1;
    chk("R9 line B disabled", 32'(qry_en), 32'h0);
    chk("R9 line B target", 32'(qry_target), 32'h0);
    qry_line = 2'd2; #1;
    chk("R9 line C target 0", 32'({qry_en, qry_target}), 32'h10);

    // R10: slot swizzle
    for (int d = 0; d < 256; d += 13) begin
      for (int p = 0; p < 4; p++) begin
        sw_devfn = 8'(d); sw_pin = 2'(p); #1;
        chk("R10 swizzle", 32'(sw_line), 32'(((d / 8) + p + 3) % 4));
      end
    end

    // R1: reset in the middle of operation
    pirq_lvl = 4'hF;
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 mid reset outputs", 32'(pic_irq), 32'h0);
    read_byte(8'h62, rd);
    chk("R1 mid reset route", 32'(rd), 32'h80);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R5 after reset all detached", 32'(pic_irq), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule